// File: doc/BRIEF.md
# Serial Port Interrupt and Status Logic

This block is the processor-facing control and status logic of a byte-wide serial interface. A processor reaches three registers through a small address port with read and write strobes: a control register of enable bits, a read-only status register of sticky flags, and a data register. Reading the data register returns the last received byte; writing it hands a byte to the transmit datapath. The transmit and receive datapaths (shifters, baud timing, bit sampling) sit outside the block and report to it through single-cycle event pulses.

One level-sensitive interrupt request is formed from the flags and the per-source enables. It has no acknowledge: software clears the cause through the data register, and the request falls in the cycle after the clearing edge. The outgoing byte is a valid-only stream: `tx_valid` pulses for one cycle with `tx_data`, and there is no ready; the datapath pushes back only by leaving the transmit-empty flag low. The incoming byte stream is also valid-only: every `rx_valid` pulse is taken, and a byte that arrives while the previous one is still unread is dropped and recorded as an overrun.

Register map: address 0 control (read/write), address 1 status (read-only), address 2 data. Control bits: 7 transmit-empty interrupt enable, 6 transmit-done interrupt enable, 5 receive interrupt enable, 3 transmitter enable, 2 receiver enable; bits 4, 1, 0 read as 0. Status bits: 7 transmit-empty, 6 transmit-done, 5 receive-ready, 3 overrun, 2 noise, 1 framing error; the rest read as 0.

Top module: `sport_intc`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0xC0 (transmit-empty and transmit-done set), `irq` is 0 and `tx_en`, `rx_en` are 0.
- R2: A write to address 0 stores bits 7, 6, 5, 3, 2 and reads back with the other bits 0; `tx_en` follows control bit 3 and `rx_en` follows control bit 2.
- R3: With control bits 7 and 3 set, `irq` is 1 whenever status bit 7 (transmit-empty) is 1.
- R4: With control bits 6 and 3 set, `irq` is 1 whenever status bit 6 (transmit-done) is 1; with bit 6 clear, transmit-done alone keeps `irq` at 0.
- R5: With control bit 5 set, `irq` is 1 whenever any of status bits 5, 3, 2, 1 is 1.
- R6: An accepted `rx_valid` without error stores `rx_data`, sets status bit 5, and the status reads as 0x20 after masking with 0x2E.
- R7: An `rx_valid` arriving while status bit 5 is 1 and the data register is not read in that cycle sets status bit 3 and leaves the stored byte unchanged.
- R8: An accepted `rx_valid` with `rx_noise` sets status bit 2; one with `rx_ferr` sets status bit 1.
- R9: A read of address 2 clears status bits 5, 3, 2, 1; if a byte arrives in the same cycle it is stored, bit 5 stays 1 and no overrun is flagged.
- R10: A write of address 2 clears status bits 7 and 6 and pulses `tx_valid` for one cycle with `tx_data` equal to the written byte, starting the cycle after the write; a `tx_empty_evt` or `tx_done_evt` in the same cycle as the write wins and leaves its flag set.
- R11: `irq` has no acknowledge and falls in the cycle after the edge that clears its last cause.
- R12: With control bit 3 clear, `tx_empty_evt` and `tx_done_evt` still set status bits 7 and 6 but neither flag raises `irq`.
- R13: With control bit 2 clear, `rx_valid` is ignored: the status and stored byte do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (2) | Register address |
| rd | input | 1 | Read strobe (read of address 2 clears receive flags) |
| wr | input | 1 | Write strobe |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Read data, combinational from `addr` |
| tx_en | output | 1 | Transmitter enable (control bit 3) |
| rx_en | output | 1 | Receiver enable (control bit 2) |
| tx_valid | output | 1 | One-cycle pulse: a byte for the transmitter |
| tx_data | output | DW (8) | Byte for the transmitter |
| tx_empty_evt | input | 1 | Pulse: transmit holding register emptied |
| tx_done_evt | input | 1 | Pulse: transmission finished |
| rx_valid | input | 1 | Pulse: a received byte is present |
| rx_data | input | DW (8) | Received byte |
| rx_noise | input | 1 | Noise seen on this byte (qualified by `rx_valid`) |
| rx_ferr | input | 1 | Framing error on this byte (qualified by `rx_valid`) |
| irq | output | 1 | Level interrupt request |

## Verification
The interrupt path is driven with each source alone under its own enable and under a neighbour's enable, so that a wrong bit position or a missing enable term shows as a request that is high or low in the wrong case. Reception is tried as a clean byte, a byte with noise, a byte with a framing error, two bytes back to back, a byte landing in the same cycle as a data read, and a byte with the receiver off; these separate overrun detection from the read/arrival race and from gating. Transmission is tried with a data write alone and a data write colliding with an empty event, telling apart the clear priority and the one-cycle outgoing pulse.

// File: rtl/sport_pkg.sv
package sport_pkg;
  // register addresses
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned A_DATA = 2;

  // control bit positions
  localparam int unsigned CB_TXE_IE  = 7;
  localparam int unsigned CB_DONE_IE = 6;
  localparam int unsigned CB_RX_IE   = 5;
  localparam int unsigned CB_TX_ON   = 3;
  localparam int unsigned CB_RX_ON   = 2;

  // status bit positions
  localparam int unsigned SB_TXE  = 7;
  localparam int unsigned SB_DONE = 6;
  localparam int unsigned SB_RDY  = 5;
  localparam int unsigned SB_OVR  = 3;
  localparam int unsigned SB_NSE  = 2;
  localparam int unsigned SB_FRM  = 1;

  localparam logic [7:0] CTRL_WMASK = 8'hEC;

  typedef struct packed {
    logic txe_ie;
    logic done_ie;
    logic rx_ie;
    logic tx_on;
    logic rx_on;
  } ctrl_t;

  typedef struct packed {
    logic txe;
    logic done;
    logic rdy;
    logic ovr;
    logic nse;
    logic frm;
  } stat_t;
endpackage

// File: rtl/sport_ctrl_reg.sv
module sport_ctrl_reg
  import sport_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output ctrl_t         ctrl,
  output logic [DW-1:0] view
);
  localparam logic [DW-1:0] MASK = DW'(CTRL_WMASK);

  logic [DW-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & MASK;
  end

  assign view         = ctrl_q;
  assign ctrl.txe_ie  = ctrl_q[CB_TXE_IE];
  assign ctrl.done_ie = ctrl_q[CB_DONE_IE];
  assign ctrl.rx_ie   = ctrl_q[CB_RX_IE];
  assign ctrl.tx_on   = ctrl_q[CB_TX_ON];
  assign ctrl.rx_on   = ctrl_q[CB_RX_ON];
endmodule

// File: rtl/sport_tx_flags.sv
module sport_tx_flags #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  input  logic          empty_evt,
  input  logic          done_evt,
  output logic          txe,
  output logic          done,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txe       <= 1'b1;
      done      <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= data_wr;
      if (data_wr) out_data <= wdata;
      // an event in the same cycle as the write wins over the clear
      if (empty_evt)    txe <= 1'b1;
      else if (data_wr) txe <= 1'b0;
      if (done_evt)     done <= 1'b1;
      else if (data_wr) done <= 1'b0;
    end
  end
endmodule

// File: rtl/sport_rx_flags.sv
module sport_rx_flags #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_on,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_noise,
  input  logic          in_ferr,
  input  logic          data_rd,
  output logic          rdy,
  output logic          ovr,
  output logic          nse,
  output logic          frm,
  output logic [DW-1:0] hold
);
  logic take;
  logic room;

  assign take = in_valid && rx_on;
  // the register has room if empty or being read in this very cycle
  assign room = !rdy || data_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      ovr  <= 1'b0;
      nse  <= 1'b0;
      frm  <= 1'b0;
      hold <= '0;
    end else begin
      if (data_rd) begin
        rdy <= 1'b0;
        ovr <= 1'b0;
        nse <= 1'b0;
        frm <= 1'b0;
      end
      if (take) begin
        if (in_noise) nse <= 1'b1;
        if (in_ferr)  frm <= 1'b1;
        if (room) begin
          rdy  <= 1'b1;
          hold <= in_data;
        end else begin
          ovr <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sport_irq.sv
module sport_irq
  import sport_pkg::*;
(
  input  ctrl_t ctrl,
  input  stat_t stat,
  output logic  irq
);
  logic tx_src;
  logic rx_src;

  assign tx_src = ctrl.tx_on && ((ctrl.txe_ie && stat.txe) || (ctrl.done_ie && stat.done));
  assign rx_src = ctrl.rx_ie && (stat.rdy || stat.ovr || stat.nse || stat.frm);
  assign irq    = tx_src || rx_src;
endmodule

// File: rtl/sport_intc.sv
module sport_intc
  import sport_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          tx_en,
  output logic          rx_en,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_empty_evt,
  input  logic          tx_done_evt,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_noise,
  input  logic          rx_ferr,
  output logic          irq
);
  ctrl_t         ctrl;
  stat_t         stat;
  logic [DW-1:0] ctrl_view;
  logic [DW-1:0] stat_view;
  logic [DW-1:0] rx_hold;
  logic          sel_ctrl, sel_stat, sel_data;
  logic          data_rd, data_wr;

  assign sel_ctrl = (addr == AW'(A_CTRL));
  assign sel_stat = (addr == AW'(A_STAT));
  assign sel_data = (addr == AW'(A_DATA));
  assign data_rd  = rd && sel_data;
  assign data_wr  = wr && sel_data;

  sport_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr && sel_ctrl),
    .wdata (wdata),
    .ctrl  (ctrl),
    .view  (ctrl_view)
  );

  sport_tx_flags #(.DW(DW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_wr   (data_wr),
    .wdata     (wdata),
    .empty_evt (tx_empty_evt),
    .done_evt  (tx_done_evt),
    .txe       (stat.txe),
    .done      (stat.done),
    .out_valid (tx_valid),
    .out_data  (tx_data)
  );

  sport_rx_flags #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_on    (ctrl.rx_on),
    .in_valid (rx_valid),
    .in_data  (rx_data),
    .in_noise (rx_noise),
    .in_ferr  (rx_ferr),
    .data_rd  (data_rd),
    .rdy      (stat.rdy),
    .ovr      (stat.ovr),
    .nse      (stat.nse),
    .frm      (stat.frm),
    .hold     (rx_hold)
  );

  sport_irq u_irq (
    .ctrl (ctrl),
    .stat (stat),
    .irq  (irq)
  );

  always_comb begin
    stat_view          = '0;
    stat_view[SB_TXE]  = stat.txe;
    stat_view[SB_DONE] = stat.done;
    stat_view[SB_RDY]  = stat.rdy;
    stat_view[SB_OVR]  = stat.ovr;
    stat_view[SB_NSE]  = stat.nse;
    stat_view[SB_FRM]  = stat.frm;
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl)      rdata = ctrl_view;
    else if (sel_stat) rdata = stat_view;
    else if (sel_data) rdata = rx_hold;
  end

  assign tx_en = ctrl.tx_on;
  assign rx_en = ctrl.rx_on;
endmodule

// File: rtl/sport_intc_chk.sv
module sport_intc_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd,
  input logic          wr,
  input logic          rx_valid,
  input logic          tx_empty_evt,
  input logic          tx_done_evt,
  input logic          rx_en,
  input logic          tx_en,
  input logic [DW-1:0] ctrl_view,
  input logic [DW-1:0] stat_view,
  input logic [DW-1:0] rx_hold,
  input logic          irq
);
  logic drd, dwr, rx_take;
  assign drd     = rd && (addr == AW'(2));
  assign dwr     = wr && (addr == AW'(2));
  assign rx_take = rx_valid && rx_en;

  // R7
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take && stat_view[5] && !drd |=> stat_view[3] && $stable(rx_hold));

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drd && !rx_take |=> (stat_view[5:1] & 5'b10111) == 5'b0);

  // R10
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && !tx_empty_evt && !tx_done_evt |=> !stat_view[7] && !stat_view[6]);

  // R12
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en && !ctrl_view[5] |-> !irq);

  // R13
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !drd |=> $stable(stat_view[5:1]) && $stable(rx_hold));

  // R6
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_view[5]) |-> $past(rx_take));
endmodule

bind sport_intc sport_intc_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr         (addr),
  .rd           (rd),
  .wr           (wr),
  .rx_valid     (rx_valid),
  .tx_empty_evt (tx_empty_evt),
  .tx_done_evt  (tx_done_evt),
  .rx_en        (rx_en),
  .tx_en        (tx_en),
  .ctrl_view    (ctrl_view),
  .stat_view    (stat_view),
  .rx_hold      (rx_hold),
  .irq          (irq)
);

// File: tb/test_sport_intc.sv
`timescale 1ns/1ps
module test_sport_intc;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          tx_en, rx_en, tx_valid, irq;
  logic [DW-1:0] tx_data;
  logic          tx_empty_evt = 1'b0, tx_done_evt = 1'b0;
  logic          rx_valid = 1'b0, rx_noise = 1'b0, rx_ferr = 1'b0;
  logic [DW-1:0] rx_data = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sport_intc #(.DW(DW), .AW(AW)) i_sport_intc (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .tx_en(tx_en), .rx_en(rx_en), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_empty_evt(tx_empty_evt), .tx_done_evt(tx_done_evt),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_noise(rx_noise),
    .rx_ferr(rx_ferr), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk); addr = AW'(a); wdata = DW'(d); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output int d);
    @(negedge clk); addr = AW'(a); rd = 1'b1; #1 d = int'(rdata);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input int a, output int d);
    @(negedge clk); addr = AW'(a); #1 d = int'(rdata);
  endtask

  task automatic rx_byte(input int d, input bit n, input bit f);
    @(negedge clk); rx_valid = 1'b1; rx_data = DW'(d); rx_noise = n; rx_ferr = f;
    @(negedge clk); rx_valid = 1'b0; rx_noise = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic pulse_tx(input bit empty, input bit done);
    @(negedge clk); tx_empty_evt = empty; tx_done_evt = done;
    @(negedge clk); tx_empty_evt = 1'b0; tx_done_evt = 1'b0;
  endtask

  task automatic t_reset;
    int v;
    peek(0, v); check(v == 8'h00, "R1 ctrl", v, 8'h00);
    peek(1, v); check(v == 8'hC0, "R1 status", v, 8'hC0);
    check(!irq && !tx_en && !rx_en, "R1 irq/enables", {irq, tx_en, rx_en}, 0);
  endtask

  task automatic t_tx_empty_irq;
    int v;
    wr_reg(0, 8'h88);
    peek(0, v); check(v == 8'h88, "R2 ctrl readback", v, 8'h88);
    check(tx_en && !rx_en, "R2 enable pins", {tx_en, rx_en}, 2'b10);
    check(irq == 1'b1, "R3 irq on empty", irq, 1);
    // data write: one-cycle outgoing pulse, flags cleared
    @(negedge clk); addr = AW'(2); wdata = 8'h5A; wr = 1'b1;
    @(posedge clk); #1;
    check(tx_valid && tx_data == 8'h5A, "R10 tx pulse", {tx_valid, tx_data}, 9'h15A);
    check(irq == 1'b0, "R11 irq falls after clear", irq, 0);
    @(negedge clk); wr = 1'b0;
    @(posedge clk); #1;
    check(tx_valid == 1'b0, "R10 pulse one cycle", tx_valid, 0);
    peek(1, v); check(v == 8'h00, "R10 flags cleared", v, 8'h00);
    pulse_tx(1, 0);
    peek(1, v); check(v == 8'h80, "R3 empty flag", v, 8'h80);
    check(irq == 1'b1, "R3 irq after empty event", irq, 1);
  endtask

  task automatic t_tx_done_irq;
    int v;
    wr_reg(0, 8'h48);
    check(irq == 1'b0, "R4 empty alone under done enable", irq, 0);
    pulse_tx(0, 1);
    peek(1, v); check(v == 8'hC0, "R4 done flag", v, 8'hC0);
    check(irq == 1'b1, "R4 irq on done", irq, 1);
  endtask

  task automatic t_tx_off;
    int v;
    wr_reg(0, 8'hC0);
    check(irq == 1'b0 && !tx_en, "R12 no irq with transmitter off", irq, 0);
    // write colliding with an empty event: event wins, done cleared
    @(negedge clk); addr = AW'(2); wdata = 8'h33; wr = 1'b1; tx_empty_evt = 1'b1;
    @(negedge clk); wr = 1'b0; tx_empty_evt = 1'b0;
    peek(1, v); check(v == 8'h80, "R10 event beats clear", v, 8'h80);
    pulse_tx(0, 1);
    peek(1, v); check(v == 8'hC0, "R12 flags still update", v, 8'hC0);
    check(irq == 1'b0, "R12 irq stays low", irq, 0);
  endtask

  task automatic t_rx_clean;
    int v;
    wr_reg(0, 8'h24);
    check(rx_en && !tx_en, "R2 receiver enable pin", {tx_en, rx_en}, 2'b01);
    check(irq == 1'b0, "R5 idle receive no irq", irq, 0);
    rx_byte(8'h3C, 0, 0);
    peek(1, v); check((v & 8'h2E) == 8'h20, "R6 clean status", v & 8'h2E, 8'h20);
    check(irq == 1'b1, "R5 irq on ready", irq, 1);
    rd_reg(2, v); check(v == 8'h3C, "R6 data", v, 8'h3C);
    peek(1, v); check((v & 8'h2E) == 8'h00, "R9 read clears", v & 8'h2E, 0);
    check(irq == 1'b0, "R11 irq falls after read", irq, 0);
  endtask

  task automatic t_overrun;
    int v;
    rx_byte(8'h11, 0, 0);
    rx_byte(8'h22, 0, 0);
    peek(1, v); check((v & 8'h2E) == 8'h28, "R7 overrun flag", v & 8'h2E, 8'h28);
    peek(2, v); check(v == 8'h11, "R7 first byte kept", v, 8'h11);
    rd_reg(2, v);
    peek(1, v); check((v & 8'h2E) == 8'h00, "R9 overrun cleared", v & 8'h2E, 0);
  endtask

  task automatic t_errors;
    int v;
    rx_byte(8'h44, 1, 0);
    peek(1, v); check((v & 8'h2E) == 8'h24, "R8 noise flag", v & 8'h2E, 8'h24);
    rd_reg(2, v);
    rx_byte(8'h55, 0, 1);
    peek(1, v); check((v & 8'h2E) == 8'h22, "R8 framing flag", v & 8'h2E, 8'h22);
    check(irq == 1'b1, "R5 irq with error", irq, 1);
    rd_reg(2, v);
    check(irq == 1'b0, "R9 errors cleared", irq, 0);
  endtask

  task automatic t_read_race;
    int v;
    rx_byte(8'h66, 0, 0);
    @(negedge clk); addr = AW'(2); rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h77;
    @(negedge clk); rd = 1'b0; rx_valid = 1'b0;
    peek(1, v); check((v & 8'h2E) == 8'h20, "R9 same-cycle byte no overrun", v & 8'h2E, 8'h20);
    peek(2, v); check(v == 8'h77, "R9 same-cycle byte stored", v, 8'h77);
  endtask

  task automatic t_rx_off;
    int v;
    wr_reg(0, 8'h20);
    check(irq == 1'b1, "R5 pending ready still requests", irq, 1);
    rd_reg(2, v);
    rx_byte(8'h99, 1, 1);
    peek(1, v); check((v & 8'h2E) == 8'h00, "R13 status unchanged", v & 8'h2E, 0);
    peek(2, v); check(v == 8'h77, "R13 data unchanged", v, 8'h77);
    check(irq == 1'b0, "R13 no irq", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_tx_empty_irq;
    t_tx_done_irq;
    t_tx_off;
    t_rx_clean;
    t_overrun;
    t_errors;
    t_read_race;
    t_rx_off;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule